// File: doc/BRIEF.md
# External Bus Arbiter for Two Peers and a Host

This block decides which agent may drive a shared external bus. The agents are two peer processors and one host. Each peer raises a request line that is synchronous to the arbiter clock. The host raises a request that may be asynchronous, and the block synchronises it before acting on it. The block returns exactly one grant at a time. It also returns a ready indication that tells the host when its transfer may proceed.

A lock input keeps the current owner on the bus for an atomic read-modify-write. While lock is high, no request can move the bus, not even a higher-priority one. Every change of owner passes through a single turnaround cycle in which nobody holds a grant.

From an idle bus, the host wins over the peers, and between the peers the lower index wins. The host can also take the bus away from an unlocked peer.

Top module: `ext_bus_arbiter`

## Requirements
- R1: While reset is asserted and after its release with no requests, every grant output is low and host_rdy is low.
- R2: At most one of host_gnt, peer_gnt[0], peer_gnt[1] is high in any cycle.
- R3: When ownership passes from one agent to another, there is exactly one cycle with no grant. A requester that is waiting is granted in the next cycle.
- R4: While lock is high and some agent holds a grant, that grant stays unchanged. This holds even if the owner drops its own request or the host requests.
- R5: From an idle bus, a synchronised host request wins over any peer request.
- R6: From an idle bus with no synchronised host request, peer 0 (peer_gnt bit 0) wins over peer 1 (bit 1).
- R7: An unlocked peer owner loses its grant on the edge where the synchronised host request is seen. The host is granted on the following edge.
- R8: host_req passes through two flip-flops. From an idle bus, host_gnt rises at the third rising edge after host_req goes high. When the host owns the bus, host_gnt falls at the third rising edge after host_req goes low.
- R9: host_rdy rises one cycle after host_gnt rises and falls together with host_gnt. It is never high without host_gnt.
- R10: An owner keeps the bus while its request stays high, unless R7 applies. Its grant drops at the first edge after its request drops, unless lock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| peer_req | input | NPEER | Bus request per peer, synchronous |
| host_req | input | 1 | Host bus request, may be asynchronous |
| lock | input | 1 | Hold current owner on the bus |
| peer_gnt | output | NPEER | Bus grant per peer |
| host_gnt | output | 1 | Bus grant to the host |
| host_rdy | output | 1 | Host transfer may proceed |

## Verification
The assertions assume that peer_req and lock change only synchronously to the clock. They also assume that host_req is held low throughout reset and stays stable long enough to cross the synchronizer. The bench changes every input one nanosecond after a rising edge and never toggles host_req faster than the synchronizer depth. Under these conditions the grant word and the synchronizer stages are well defined at every edge that the properties inspect.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int unsigned ARB_SYNC_DEFAULT = 2;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_phase_e;
endpackage

// File: rtl/bus_arb_sync.sv
module bus_arb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b0;
    else        stage_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b0;
      else        stage_q[i] <= stage_q[i-1];
    end

    // R8: each stage takes the value of the stage before it
    p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stage_q[i] == $past(stage_q[i-1]));
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/bus_arb_pick.sv
module bus_arb_pick #(
  parameter int unsigned NPEER = 2,
  localparam int unsigned NREQ = NPEER + 1
) (
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] win
);
  logic [NPEER:0] none_below;

  assign none_below[0] = 1'b1;

  for (genvar i = 0; i < NPEER; i++) begin : g_peer
    assign win[i]           = req[i] & none_below[i] & ~req[NPEER];
    assign none_below[i+1]  = none_below[i] & ~req[i];
  end

  assign win[NPEER] = req[NPEER];
endmodule

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter
  import bus_arb_pkg::*;
#(
  parameter int unsigned NPEER       = 2,
  parameter int unsigned SYNC_STAGES = ARB_SYNC_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPEER-1:0] peer_req,
  input  logic             host_req,
  input  logic             lock,
  output logic [NPEER-1:0] peer_gnt,
  output logic             host_gnt,
  output logic             host_rdy
);
  localparam int unsigned NREQ     = NPEER + 1;
  localparam int unsigned HOST_BIT = NPEER;

  logic            host_req_s;
  logic [NREQ-1:0] req_all;
  logic [NREQ-1:0] win;
  logic [NREQ-1:0] gnt_q, gnt_d;
  logic            gnt_en;
  logic            rdy_q, rdy_d, rdy_en;
  logic            owner_req, owner_is_peer, preempt, keep;
  arb_phase_e      phase;

  bus_arb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (host_req),
    .q     (host_req_s)
  );

  assign req_all = {host_req_s, peer_req};

  bus_arb_pick #(.NPEER(NPEER)) u_pick (
    .req (req_all),
    .win (win)
  );

  assign phase = (|gnt_q) ? ARB_BUSY : ARB_IDLE;

  always_comb begin
    owner_req     = |(gnt_q & req_all);
    owner_is_peer = |gnt_q[NPEER-1:0];
    preempt       = owner_is_peer & host_req_s;
    keep          = lock | (owner_req & ~preempt);
    gnt_d         = '0;
    unique case (phase)
      ARB_IDLE: gnt_d = win;
      ARB_BUSY: gnt_d = keep ? gnt_q : '0;
      default:  gnt_d = '0;
    endcase
    gnt_en = (gnt_d != gnt_q);
    rdy_d  = gnt_q[HOST_BIT] & gnt_d[HOST_BIT];
    rdy_en = (rdy_d != rdy_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gnt_q <= '0;
    else if (gnt_en) gnt_q <= gnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdy_q <= 1'b0;
    else if (rdy_en) rdy_q <= rdy_d;
  end

  assign peer_gnt = gnt_q[NPEER-1:0];
  assign host_gnt = gnt_q[HOST_BIT];
  assign host_rdy = rdy_q;

  // R2: single owner
  p_one_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_gnt, peer_gnt}));

  // R3: owner never changes without an empty cycle in between
  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q != '0 && $past(gnt_q) != '0) |-> gnt_q == $past(gnt_q));

  // R4: lock freezes an owned bus
  p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && gnt_q != '0) |=> gnt_q == $past(gnt_q));

  // R5: host wins from idle
  p_host_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q == '0 && host_req_s) |=> host_gnt);

  // R6: lower peer wins a tie from idle
  p_low_peer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q == '0 && !host_req_s && peer_req[0]) |=> peer_gnt[0]);

  // R7: unlocked peer yields to host
  p_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|peer_gnt) && host_req_s && !lock) |=> gnt_q == '0);

  // R9: ready only with grant, and not in the grant's first cycle
  p_rdy_gnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdy |-> host_gnt);
  p_rdy_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_gnt) |-> !host_rdy);
endmodule

// File: tb/ext_bus_arbiter_test.sv
module ext_bus_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] peer_req;
  logic       host_req;
  logic       lock;
  logic [1:0] peer_gnt;
  logic       host_gnt;
  logic       host_rdy;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  ext_bus_arbiter uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .peer_req (peer_req),
    .host_req (host_req),
    .lock     (lock),
    .peer_gnt (peer_gnt),
    .host_gnt (host_gnt),
    .host_rdy (host_rdy)
  );

  wire [2:0] gw = {host_gnt, peer_gnt};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
      chk("R2 one grant", 32'($countones(gw) <= 1), 32'd1);
    end
  endtask

  initial begin
    rst_n = 1'b0; peer_req = '0; host_req = 1'b0; lock = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 grants in reset", gw, 0);
    chk("R1 ready in reset", host_rdy, 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 grants after reset", gw, 0);
    chk("R1 ready after reset", host_rdy, 0);

    // peer sweep from idle
    for (int c = 0; c < 4; c++) begin
      peer_req = 2'(c);
      step(1);
      chk("R6 peer pick", gw, (c == 0) ? 0 : ((c % 2 == 1) ? 1 : 2));
      peer_req = '0;
      step(1);
      chk("R10 release", gw, 0);
    end

    // R10 hold while requesting
    peer_req = 2'b10;
    step(1); chk("R10 grant peer1", gw, 2);
    step(3); chk("R10 hold peer1", gw, 2);
    // R3 peer to peer handover
    peer_req = 2'b11;
    step(2); chk("R10 no peer preempt", gw, 2);
    peer_req = 2'b01;
    step(1); chk("R3 gap", gw, 0);
    step(1); chk("R3 next owner", gw, 1);
    peer_req = '0;
    step(1); chk("R10 drop", gw, 0);

    // R8 host latency and R9 ready
    host_req = 1'b1;
    step(2); chk("R8 sync delay", gw, 0);
    step(1); chk("R8 host granted", gw, 4);
    chk("R9 ready late", host_rdy, 0);
    step(1); chk("R9 ready up", host_rdy, 1);
    peer_req = 2'b11;
    step(3); chk("R10 host holds", gw, 4);
    host_req = 1'b0;
    step(2); chk("R8 release delay", gw, 4);
    chk("R9 ready held", host_rdy, 1);
    step(1); chk("R8 host released", gw, 0);
    chk("R9 ready down", host_rdy, 0);
    step(1); chk("R6 peer0 after gap", gw, 1);

    // R7 preemption of unlocked peer
    host_req = 1'b1;
    step(2); chk("R7 before sync", gw, 1);
    step(1); chk("R7 peer dropped", gw, 0);
    step(1); chk("R7 host granted", gw, 4);

    // host to peer1
    peer_req = 2'b10; host_req = 1'b0;
    step(3); chk("R3 host gap", gw, 0);
    step(1); chk("R3 peer1 granted", gw, 2);

    // R4 lock on peer owner
    lock = 1'b1; host_req = 1'b1; peer_req = '0;
    step(6); chk("R4 peer locked", gw, 2);
    chk("R9 no ready", host_rdy, 0);
    lock = 1'b0;
    step(1); chk("R4 unlock gap", gw, 0);
    step(1); chk("R5 host after unlock", gw, 4);

    // R4 lock on host owner
    lock = 1'b1; host_req = 1'b0; peer_req = 2'b11;
    step(5); chk("R4 host locked", gw, 4);
    chk("R9 ready while locked", host_rdy, 1);
    lock = 1'b0;
    step(1); chk("R4 host unlock gap", gw, 0);
    step(1); chk("R6 peer0 wins", gw, 1);

    // R5 simultaneous host and peers at idle
    peer_req = '0;
    step(1); chk("R10 idle", gw, 0);
    host_req = 1'b1;
    step(2);
    peer_req = 2'b11;
    step(1); chk("R5 host beats peers", gw, 4);

    host_req = 1'b0; peer_req = '0;
    step(4); chk("R1 idle again", gw, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule